// File: doc/BRIEF.md
# Mode-Dependent CPU Clock Prescaler

This block turns a fast source clock into a one-cycle clock-enable strobe at the CPU rate. Three inputs choose the division ratio: an operating-mode select, a prescaler enable and a 2-bit rate code. In standalone mode the source is taken to run at 12 MHz. In USB mode it is taken to run at 48 MHz. When the prescaler is off, the block does not fall back to divide-by-one. It uses a default divisor that depends on the mode, and the rate code is ignored. A second strobe, for the data-transfer coprocessor, runs at a divisor fixed by the mode alone. A low-speed flag warns when the CPU runs at 2 MHz or slower in USB mode, since at that rate the CPU can starve the USB buffer.

Each strobe comes from a period counter built around a three-state machine:

- **PS_INIT** is the state held in reset and for the first cycle after it. It loads the default setting and a count of 1. The counter goes to PS_TICK when the default divisor is 2 and to PS_COUNT otherwise.
- **PS_COUNT** increments the count and holds the active setting. The counter goes to PS_TICK once the count reaches divisor−2 and stays in PS_COUNT otherwise.
- **PS_TICK** drives the strobe high. It clears the count and captures the setting on the inputs at that moment, then always goes back to PS_COUNT.

A new setting therefore takes effect only at a period boundary. All divisors must be 2 or more.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: With pre_en=0 the CPU divisor is 4 when usb_mode=0 and 8 when usb_mode=1, whatever pre_code holds.
- R2: With usb_mode=0 and pre_en=1, pre_code values 2'b00, 2'b01, 2'b10 and 2'b11 select CPU divisors 2, 8, 16 and 32.
- R3: With usb_mode=1 and pre_en=1, pre_code values 2'b00, 2'b01, 2'b10 and 2'b11 select CPU divisors 6, 24, 48 and 192.
- R4: For an active divisor N, cpu_ce is high for exactly one source cycle and then low for N−1 cycles.
- R5: The inputs are sampled only in the cycle in which cpu_ce is high, and they set the next period. A change made during a period does not shorten or stretch that period.
- R6: While rst_n=0, cpu_ce, copro_ce and slow_flag are low. After reset is released, the first cpu_ce pulse comes one full default period later (4 cycles with usb_mode=0, 8 with usb_mode=1). Reset is released away from a clock edge, and the cycle in which it is released counts as the first.
- R7: copro_ce pulses once every 2 cycles when usb_mode=0 and once every 8 cycles when usb_mode=1. Neither pre_en nor pre_code has any effect on it.
- R8: slow_flag is high exactly while the active CPU setting has usb_mode=1 and a divisor of 24 or more (2 MHz or below). It updates at the same period boundary as the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_mode | input | 1 | 0 = standalone mode (12 MHz source), 1 = USB mode (48 MHz source) |
| pre_en | input | 1 | Prescaler enable; 0 selects the mode default divisor |
| pre_code | input | 2 | Prescaler rate code |
| cpu_ce | output | 1 | One-cycle CPU clock enable |
| copro_ce | output | 1 | One-cycle coprocessor clock enable |
| slow_flag | output | 1 | USB mode with CPU at or below 2 MHz |

## Verification
The assertions assume that every configured divisor is at least 2, which the default parameters guarantee. They also assume that the mode, enable and code inputs are stable across each clock edge. The bench meets both conditions by changing the inputs only at falling edges. It measures periods as counts of falling edges from one strobe to the next. In the boundary test it changes the code one cycle after a strobe has been sampled, so the change lands inside a period already in progress. The bench also reasserts reset under each mode to check the first period after reset.

// File: rtl/cpu_ps_pkg.sv
package cpu_ps_pkg;

    typedef enum logic [1:0] {
        PS_INIT  = 2'd0,
        PS_COUNT = 2'd1,
        PS_TICK  = 2'd2
    } ps_state_e;

endpackage

// File: rtl/ps_rate_select.sv
module ps_rate_select #(
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned SA_DEF_DIV   = 4,
    parameter int unsigned USB_DEF_DIV  = 8,
    parameter int unsigned SA_DIV  [4]  = '{2, 8, 16, 32},
    parameter int unsigned USB_DIV [4]  = '{6, 24, 48, 192},
    parameter int unsigned SA_CP_DIV    = 2,
    parameter int unsigned USB_CP_DIV   = 8,
    parameter int unsigned SLOW_MIN_DIV = 24
) (
    input  logic             usb_mode,
    input  logic             pre_en,
    input  logic [1:0]       pre_code,
    output logic [DIV_W-1:0] run_div,
    output logic             run_slow,
    output logic [DIV_W-1:0] dflt_div,
    output logic             dflt_slow,
    output logic [DIV_W-1:0] cp_div
);

    localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_MIN_DIV);

    logic [DIV_W-1:0] table_div;

    always_comb begin
        if (usb_mode) begin
            table_div = DIV_W'(USB_DIV[pre_code]);
            dflt_div  = DIV_W'(USB_DEF_DIV);
            cp_div    = DIV_W'(USB_CP_DIV);
        end else begin
            table_div = DIV_W'(SA_DIV[pre_code]);
            dflt_div  = DIV_W'(SA_DEF_DIV);
            cp_div    = DIV_W'(SA_CP_DIV);
        end
        run_div   = pre_en ? table_div : dflt_div;
        run_slow  = usb_mode && (run_div >= SLOW_LIM);
        dflt_slow = usb_mode && (dflt_div >= SLOW_LIM);
    end

endmodule

// File: rtl/ps_period_counter.sv
module ps_period_counter
    import cpu_ps_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] init_div,
    input  logic             init_tag,
    input  logic [DIV_W-1:0] next_div,
    input  logic             next_tag,
    output logic             tick,
    output logic [DIV_W-1:0] act_div,
    output logic             act_tag
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             tag_q;

    // next-state logic
    always_comb begin
        unique case (state_q)
            PS_INIT:  state_d = (init_div == TWO) ? PS_TICK : PS_COUNT;
            PS_COUNT: state_d = (cnt_q == div_q - TWO) ? PS_TICK : PS_COUNT;
            PS_TICK:  state_d = PS_COUNT;
            default:  state_d = PS_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_INIT;
        else        state_q <= state_d;
    end

    // count and active setting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= '0;
            tag_q <= 1'b0;
        end else begin
            unique case (state_q)
                PS_INIT: begin
                    cnt_q <= ONE;
                    div_q <= init_div;
                    tag_q <= init_tag;
                end
                PS_COUNT: cnt_q <= cnt_q + ONE;
                PS_TICK: begin
                    cnt_q <= '0;
                    div_q <= next_div;
                    tag_q <= next_tag;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        tick    = (state_q == PS_TICK);
        act_div = div_q;
        act_tag = tag_q;
    end

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_INIT) |-> (cnt_q < div_q));

    assert_hold_mid_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_COUNT) |=> ($stable(div_q) && $stable(tag_q)));

    assert_first_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_INIT) |=> (state_q != PS_INIT));

endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler #(
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned SA_DEF_DIV   = 4,
    parameter int unsigned USB_DEF_DIV  = 8,
    parameter int unsigned SA_DIV  [4]  = '{2, 8, 16, 32},
    parameter int unsigned USB_DIV [4]  = '{6, 24, 48, 192},
    parameter int unsigned SA_CP_DIV    = 2,
    parameter int unsigned USB_CP_DIV   = 8,
    parameter int unsigned SLOW_MIN_DIV = 24
) (
    input  logic       clk_src,
    input  logic       rst_n,
    input  logic       usb_mode,
    input  logic       pre_en,
    input  logic [1:0] pre_code,
    output logic       cpu_ce,
    output logic       copro_ce,
    output logic       slow_flag
);

    logic [DIV_W-1:0] run_div, dflt_div, cp_div;
    logic             run_slow, dflt_slow;
    logic [DIV_W-1:0] cpu_div, cop_div;
    logic             cpu_slow, cop_usb;

    ps_rate_select #(
        .DIV_W(DIV_W), .SA_DEF_DIV(SA_DEF_DIV), .USB_DEF_DIV(USB_DEF_DIV),
        .SA_DIV(SA_DIV), .USB_DIV(USB_DIV), .SA_CP_DIV(SA_CP_DIV),
        .USB_CP_DIV(USB_CP_DIV), .SLOW_MIN_DIV(SLOW_MIN_DIV)
    ) u_sel (
        .usb_mode (usb_mode),
        .pre_en   (pre_en),
        .pre_code (pre_code),
        .run_div  (run_div),
        .run_slow (run_slow),
        .dflt_div (dflt_div),
        .dflt_slow(dflt_slow),
        .cp_div   (cp_div)
    );

    ps_period_counter #(.DIV_W(DIV_W)) u_cpu_cnt (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .init_div(dflt_div),
        .init_tag(dflt_slow),
        .next_div(run_div),
        .next_tag(run_slow),
        .tick    (cpu_ce),
        .act_div (cpu_div),
        .act_tag (cpu_slow)
    );

    ps_period_counter #(.DIV_W(DIV_W)) u_cop_cnt (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .init_div(cp_div),
        .init_tag(usb_mode),
        .next_div(cp_div),
        .next_tag(usb_mode),
        .tick    (copro_ce),
        .act_div (cop_div),
        .act_tag (cop_usb)
    );

    assign slow_flag = cpu_slow;

    assert_default_sa_R1: assert property (@(posedge clk_src) disable iff (!rst_n)
        (cpu_ce && !pre_en && !usb_mode) |=> (cpu_div == DIV_W'(SA_DEF_DIV)));

    assert_default_usb_R1: assert property (@(posedge clk_src) disable iff (!rst_n)
        (cpu_ce && !pre_en && usb_mode) |=> (cpu_div == DIV_W'(USB_DEF_DIV)));

    assert_slow_limit_R8: assert property (@(posedge clk_src) disable iff (!rst_n)
        slow_flag |-> (cpu_div >= DIV_W'(SLOW_MIN_DIV)));

    assert_copro_rate_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
        copro_ce |=> (cop_div == (cop_usb ? DIV_W'(USB_CP_DIV) : DIV_W'(SA_CP_DIV))));

endmodule

// File: tb/tb_cpu_clk_prescaler.sv
module tb_cpu_clk_prescaler;

    logic       clk_src = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_mode = 1'b0;
    logic       pre_en = 1'b0;
    logic [1:0] pre_code = 2'b00;
    logic       cpu_ce, copro_ce, slow_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk_src = ~clk_src;

    cpu_clk_prescaler dut (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .usb_mode (usb_mode),
        .pre_en   (pre_en),
        .pre_code (pre_code),
        .cpu_ce   (cpu_ce),
        .copro_ce (copro_ce),
        .slow_flag(slow_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cpu();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_src);
            if (cpu_ce) return;
        end
    endtask

    task automatic wait_cop();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_src);
            if (copro_ce) return;
        end
    endtask

    // called right after seeing cpu_ce high at a falling edge
    task automatic gap_cpu(output int n);
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_src);
            n++;
            if (cpu_ce) return;
        end
    endtask

    task automatic gap_cop(output int n);
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_src);
            n++;
            if (copro_ce) return;
        end
    endtask

    task automatic setup(input bit usb, input bit en, input logic [1:0] code);
        @(negedge clk_src);
        usb_mode = usb;
        pre_en   = en;
        pre_code = code;
        wait_cpu();  // boundary that captures the new setting
    endtask

    task automatic do_reset(input bit usb, input int exp_first);
        int k;
        @(negedge clk_src);
        rst_n = 1'b0;
        usb_mode = usb;
        pre_en = 1'b1;
        pre_code = 2'b11;
        @(negedge clk_src);
        @(negedge clk_src);
        check(!cpu_ce && !copro_ce && !slow_flag, "R6 outputs low in reset",
              {cpu_ce, copro_ce, slow_flag}, 0);
        rst_n = 1'b1;
        k = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_src);
            k++;
            if (cpu_ce) break;
        end
        // release counts as cycle one: pulse seen at falling edge N-1
        check(k == exp_first - 1, "R6 first pulse after reset", k, exp_first - 1);
    endtask

    task automatic test_reset();
        do_reset(1'b0, 4);
        do_reset(1'b1, 8);
    endtask

    task automatic test_default_R1();
        int n;
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                setup(m[0], 1'b0, c[1:0]);
                gap_cpu(n);
                check(n == (m == 0 ? 4 : 8), "R1 default divisor", n, (m == 0 ? 4 : 8));
            end
        end
    endtask

    task automatic test_sa_R2();
        int exp_d [4] = '{2, 8, 16, 32};
        int n;
        for (int c = 0; c < 4; c++) begin
            setup(1'b0, 1'b1, c[1:0]);
            gap_cpu(n);
            check(n == exp_d[c], "R2 standalone divisor", n, exp_d[c]);
        end
    endtask

    task automatic test_usb_R3();
        int exp_d [4] = '{6, 24, 48, 192};
        int n;
        for (int c = 0; c < 4; c++) begin
            setup(1'b1, 1'b1, c[1:0]);
            gap_cpu(n);
            check(n == exp_d[c], "R3 usb divisor", n, exp_d[c]);
        end
    endtask

    task automatic test_width_R4();
        int hi;
        setup(1'b1, 1'b1, 2'b01);
        wait_cpu();
        hi = 0;
        for (int i = 0; i < 24; i++) begin
            if (cpu_ce) hi++;
            @(negedge clk_src);
        end
        check(hi == 1, "R4 one high cycle per period", hi, 1);
        setup(1'b0, 1'b1, 2'b00);
        wait_cpu();
        @(negedge clk_src);
        check(!cpu_ce, "R4 low after pulse at divisor 2", cpu_ce, 0);
    endtask

    task automatic test_boundary_R5();
        int n;
        setup(1'b1, 1'b1, 2'b11);
        wait_cpu();  // a 192 period begins here
        @(negedge clk_src);
        pre_code = 2'b00;
        n = 1;
        for (int i = 0; i < 600; i++) begin
            if (cpu_ce) break;
            @(negedge clk_src);
            n++;
        end
        check(n == 192, "R5 period in progress kept", n, 192);
        gap_cpu(n);
        check(n == 6, "R5 new divisor after boundary", n, 6);
    endtask

    task automatic test_copro_R7();
        int n;
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk_src);
                usb_mode = m[0];
                pre_en = c[0];
                pre_code = c[1:0];
                wait_cop();
                wait_cop();
                gap_cop(n);
                check(n == (m == 0 ? 2 : 8), "R7 coprocessor divisor", n, (m == 0 ? 2 : 8));
            end
        end
        // code change mid-period has no effect on coprocessor
        wait_cop();
        @(negedge clk_src);
        pre_code = 2'b10;
        n = 1;
        for (int i = 0; i < 600; i++) begin
            if (copro_ce) break;
            @(negedge clk_src);
            n++;
        end
        check(n == 8, "R7 coprocessor unaffected by code", n, 8);
    endtask

    task automatic slow_case(input bit usb, input bit en, input logic [1:0] code, input bit exp);
        setup(usb, en, code);
        @(negedge clk_src);
        check(slow_flag == exp, "R8 slow flag", slow_flag, exp);
    endtask

    task automatic test_slow_R8();
        slow_case(1'b1, 1'b1, 2'b00, 1'b0);
        slow_case(1'b1, 1'b1, 2'b01, 1'b1);
        slow_case(1'b1, 1'b1, 2'b11, 1'b1);
        slow_case(1'b0, 1'b1, 2'b11, 1'b0);
        slow_case(1'b1, 1'b0, 2'b11, 1'b0);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_default_R1();
        test_sa_R2();
        test_usb_R3();
        test_width_R4();
        test_boundary_R5();
        test_copro_R7();
        test_slow_R8();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule